// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a stored mode word and the starting column of a read or write command into the column address for every beat of the burst. It decodes the mode word for the burst length, the beat ordering and the single-location write override. While a burst runs it presents one column per clock, a beat-valid flag and a last-beat flag. Fixed-length bursts stay inside the aligned block of burst-length columns and wrap at its edge. A full-page burst steps through the whole row, wraps from the top column to column zero, and runs until it is terminated.

A controller loads the mode word whenever it programs the memory's mode register. It then pulses `start` with the command's column and direction. A new `start` during a burst cuts the old burst short and begins the new one, the same way a following command truncates a burst. `stop` ends a burst in the manner of a burst-terminate command. Command issue, data alignment to CAS latency and bank state are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, `beat_valid` and `last_beat` are low. The stored mode word resets to 10'h020 (one-beat bursts, sequential order, latency code 010, standard operating mode).
- R2: A one-cycle `mode_we` stores `mode_word`. The fields are: bits [2:0] length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 order (0 sequential, 1 interleaved), bits [6:4] latency code, bits [8:7] operating mode, and bit 9 write override.
- R3: When `start` is sampled high and the stored mode is legal, beat 0 appears in the following cycle with `beat_valid` high and `col_out` equal to `start_col`.
- R4: In sequential order with length L, beat k carries the block base (start column with its low log2(L) bits cleared) plus ((start column mod L) + k) mod L.
- R5: In interleaved order with length L, beat k carries the block base plus ((start column mod L) XOR k).
- R6: A fixed-length burst raises `last_beat` on beat L-1 only. In the next cycle `beat_valid` is low unless a new burst was started.
- R7: With bit 9 set, a write start (`start_wr` high) gives a single beat with `last_beat` high. A read start still uses the programmed length.
- R8: Length code 111 gives a full-page burst. The column rises by one each beat and wraps from 2^COL_W-1 to 0, whatever bit 3 holds. `last_beat` never rises.
- R9: `stop` sampled high during a burst with `start` low makes `beat_valid` low in the next cycle. When `start` and `stop` are high together, the start wins.
- R10: A legal `start` during a running burst drops the old burst. Beat 0 of the new burst appears in the next cycle.
- R11: If the stored mode is reserved (length code 100, 101 or 110; operating mode other than 00; latency code other than 010 or 011), `start` is ignored and any running burst continues unchanged.
- R12: Writing the mode word during a burst does not change the length, order or columns of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Stores `mode_word` into the mode register |
| mode_word | input | 10 | Mode word fields (see R2) |
| start | input | 1 | Starts a burst at `start_col` |
| start_wr | input | 1 | The starting command is a write |
| start_col | input | COL_W | Starting column of the command |
| stop | input | 1 | Terminates the running burst |
| col_out | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The properties assume that every control input is synchronous to `clk` and stable around the rising edge. They also assume that `start_col` is meaningful only in the cycle `start` is high. The stimulus changes every input only on the falling edge and drives `start`, `stop` and `mode_we` as one-cycle pulses. It keeps `mode_word` within the ten defined bits, so every reserved combination the properties reason about is reached on purpose, through R11 cases and never by accident.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int MODE_W     = 10;
  localparam int LEN_LSB    = 0;
  localparam int ORDER_BIT  = 3;
  localparam int LAT_LSB    = 4;
  localparam int OPM_LSB    = 7;
  localparam int WRSGL_BIT  = 9;

  localparam logic [MODE_W-1:0] MODE_RESET = 10'h020;

  typedef struct packed {
    logic       legal;
    logic       wr_single;
    logic       ilv;
    logic       full;
    logic [1:0] lg;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] w);
    mode_cfg_t  c;
    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic [1:0] opm;
    logic       len_ok;
    logic       lat_ok;
    len_code    = w[LEN_LSB +: 3];
    lat_code    = w[LAT_LSB +: 3];
    opm         = w[OPM_LSB +: 2];
    len_ok      = (len_code[2] == 1'b0) || (len_code == 3'b111);
    lat_ok      = (lat_code == 3'b010) || (lat_code == 3'b011);
    c.full      = (len_code == 3'b111);
    c.lg        = c.full ? 2'd0 : len_code[1:0];
    c.ilv       = w[ORDER_BIT];
    c.wr_single = w[WRSGL_BIT];
    c.legal     = len_ok && lat_ok && (opm == 2'b00);
    return c;
  endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import burst_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] word,
  output mode_cfg_t         cfg
);

  logic [MODE_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= MODE_RESET;
    end else if (we) begin
      word_q <= word;
    end
  end

  always_comb cfg = decode_mode(word_q);

endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_cfg_t        cfg,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] cnt,
  output logic [1:0]       lg,
  output logic             full,
  output logic             ilv,
  output logic             launch,
  output logic             last
);

  logic             single_ovr;
  logic [COL_W-1:0] len_mask;

  assign launch     = start && cfg.legal;
  assign single_ovr = start_wr && cfg.wr_single;
  assign len_mask   = (COL_W'(1) << lg) - COL_W'(1);
  assign last       = active && !full && (cnt == len_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      lg     <= 2'd0;
      full   <= 1'b0;
      ilv    <= 1'b0;
    end else if (launch) begin
      active <= 1'b1;
      base   <= start_col;
      cnt    <= '0;
      lg     <= single_ovr ? 2'd0 : cfg.lg;
      full   <= single_ovr ? 1'b0 : cfg.full;
      ilv    <= cfg.ilv;
    end else if (active) begin
      if (stop || last) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/bcg_addr.sv
module bcg_addr #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [1:0]       lg,
  input  logic             full,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] b,
    input logic [COL_W-1:0] k,
    input logic [1:0]       l,
    input logic             f,
    input logic             x
  );
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low;
    mask = (COL_W'(1) << l) - COL_W'(1);
    if (f) begin
      return b + k;
    end
    low = x ? ((b ^ k) & mask) : ((b + k) & mask);
    return (b & ~mask) | low;
  endfunction

  always_comb col = beat_col(base, cnt, lg, full, ilv);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              start_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              beat_valid,
  output logic              last_beat
);

  mode_cfg_t        cfg;
  logic             mode_legal;
  logic             seq_active;
  logic [COL_W-1:0] seq_base;
  logic [COL_W-1:0] seq_cnt;
  logic [1:0]       seq_lg;
  logic             seq_full;
  logic             seq_ilv;
  logic             seq_launch;
  logic             seq_last;

  bcg_mode_reg u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mode_we),
    .word (mode_word),
    .cfg  (cfg)
  );

  assign mode_legal = cfg.legal;

  bcg_seq #(.COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .start    (start),
    .start_wr (start_wr),
    .start_col(start_col),
    .stop     (stop),
    .active   (seq_active),
    .base     (seq_base),
    .cnt      (seq_cnt),
    .lg       (seq_lg),
    .full     (seq_full),
    .ilv      (seq_ilv),
    .launch   (seq_launch),
    .last     (seq_last)
  );

  bcg_addr #(.COL_W(COL_W)) u_addr (
    .base(seq_base),
    .cnt (seq_cnt),
    .lg  (seq_lg),
    .full(seq_full),
    .ilv (seq_ilv),
    .col (col_out)
  );

  assign beat_valid = seq_active;
  assign last_beat  = seq_last;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             beat_valid,
  input logic             last_beat,
  input logic             mode_legal,
  input logic             full_burst
);

  a_r6_last_inside_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  a_r3_first_beat_column: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_legal) |=> (beat_valid && col_out == $past(start_col)));

  a_r6_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);

  a_r9_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && stop && !start) |=> !beat_valid);

  a_r11_reserved_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid && start && !mode_legal) |=> !beat_valid);

  a_r4_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !stop && !start) |=> beat_valid);

  a_r8_full_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && full_burst && !stop && !start) |=>
      (col_out == $past(col_out) + COL_W'(1)));

  a_r8_full_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && full_burst) |-> !last_beat);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .start_col (start_col),
  .col_out   (col_out),
  .beat_valid(beat_valid),
  .last_beat (last_beat),
  .mode_legal(mode_legal),
  .full_burst(seq_full)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_we = 1'b0;
  logic [9:0]       mode_word = '0;
  logic             start = 1'b0;
  logic             start_wr = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             beat_valid;
  logic             last_beat;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    int col;
    bit last;
    int req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_word(mode_word),
    .start(start), .start_wr(start_wr), .start_col(start_col), .stop(stop),
    .col_out(col_out), .beat_valid(beat_valid), .last_beat(last_beat)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode word: [2:0] length code, [3] order, [6:4] latency, [8:7] op mode, [9] write override
  function automatic logic [9:0] mw(input int code, input bit ilv, input bit wrs);
    return {wrs, 2'b00, 3'b010, ilv, 3'(code)};
  endfunction

  function automatic int exp_col(input int c, input int k, input int bl,
                                 input bit ilv, input bit full);
    int blk;
    int off;
    if (full) return (c + k) % PAGE;
    blk = (c / bl) * bl;
    off = c % bl;
    if (ilv) return blk + (off ^ k);
    return blk + ((off + k) % bl);
  endfunction

  task automatic push(input int c, input int n, input int bl, input bit ilv,
                      input bit full, input int req);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.col  = exp_col(c, k, bl, ilv, full);
      it.last = !full && (k == bl - 1);
      it.req  = req;
      sb.push_back(it);
    end
  endtask

  task automatic set_mode(input logic [9:0] w);
    mode_word = w;
    mode_we   = 1'b1;
    @(negedge clk);
    mode_we   = 1'b0;
  endtask

  task automatic pulse_start(input int c, input bit wr);
    start     = 1'b1;
    start_wr  = wr;
    start_col = COL_W'(c);
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(sb.size() == 0, req, "beats missing", sb.size(), 0);
    sb.delete();
  endtask

  // monitor: pops one expected beat per valid output cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (beat_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R3", "unexpected beat col", int'(col_out), -1);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(int'(col_out) == it.col, $sformatf("R%0d", it.req), "column",
              int'(col_out), it.col);
          chk(last_beat == it.last, $sformatf("R%0d", it.req), "last_beat",
              int'(last_beat), int'(it.last));
        end
      end else begin
        if (last_beat) chk(1'b0, "R6", "last without valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(!beat_valid, "R1", "valid in reset", int'(beat_valid), 0);
    chk(!last_beat, "R1", "last in reset", int'(last_beat), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!beat_valid, "R1", "valid after reset", int'(beat_valid), 0);

    // R1/R2: reset mode is a one-beat burst
    push(77, 1, 1, 0, 0, 2); pulse_start(77, 0); drain("R2");

    // R4: sequential bursts of 2, 4 and 8
    set_mode(mw(1, 0, 0)); push(9, 2, 2, 0, 0, 4);  pulse_start(9, 0);  drain("R4");
    set_mode(mw(2, 0, 0)); push(6, 4, 4, 0, 0, 4);  pulse_start(6, 0);  drain("R4");
    set_mode(mw(3, 0, 0)); push(13, 8, 8, 0, 0, 4); pulse_start(13, 0); drain("R4");

    // R5: interleaved order
    set_mode(mw(3, 1, 0)); push(13, 8, 8, 1, 0, 5); pulse_start(13, 0); drain("R5");
    set_mode(mw(2, 1, 0)); push(2, 4, 4, 1, 0, 5);  pulse_start(2, 0);  drain("R5");

    // R7: write override gives one beat; read keeps length 8
    set_mode(mw(3, 0, 1)); push(40, 1, 1, 0, 0, 7); pulse_start(40, 1); drain("R7");
    push(40, 8, 8, 0, 0, 7); pulse_start(40, 0); drain("R7");

    // R8/R9: full page wraps at the page end, stopped after 8 beats
    set_mode(mw(7, 0, 0)); push(PAGE - 4, 8, 1, 0, 1, 8);
    pulse_start(PAGE - 4, 0); repeat (7) @(negedge clk); pulse_stop(); drain("R8");
    // R8: order bit ignored in full page
    set_mode(mw(7, 1, 0)); push(PAGE - 2, 6, 1, 0, 1, 8);
    pulse_start(PAGE - 2, 0); repeat (5) @(negedge clk); pulse_stop(); drain("R8");

    // R9: start together with stop restarts
    set_mode(mw(7, 0, 0)); push(1020, 3, 1, 0, 1, 9); push(500, 4, 1, 0, 1, 9);
    pulse_start(1020, 0); repeat (2) @(negedge clk);
    stop = 1'b1; pulse_start(500, 0); stop = 1'b0;
    repeat (3) @(negedge clk); pulse_stop(); drain("R9");

    // R9: stop truncates a fixed burst
    set_mode(mw(3, 0, 0)); push(0, 3, 8, 0, 0, 9);
    pulse_start(0, 0); repeat (2) @(negedge clk); pulse_stop(); drain("R9");

    // R10: new start truncates running burst
    push(5, 3, 8, 0, 0, 10); push(20, 8, 8, 0, 0, 10);
    pulse_start(5, 0); repeat (2) @(negedge clk); pulse_start(20, 0); drain("R10");

    // R11: reserved length, op mode and latency codes ignore start
    set_mode(10'h025); pulse_start(3, 0); repeat (3) @(negedge clk);
    chk(!beat_valid, "R11", "reserved length start", int'(beat_valid), 0);
    set_mode(10'h0A3); pulse_start(3, 0); repeat (3) @(negedge clk);
    chk(!beat_valid, "R11", "reserved op mode start", int'(beat_valid), 0);
    set_mode(10'h003); pulse_start(3, 0); repeat (3) @(negedge clk);
    chk(!beat_valid, "R11", "reserved latency start", int'(beat_valid), 0);
    drain("R11");

    // R12 + R11: mode writes and an ignored start during a running burst
    set_mode(mw(3, 0, 0)); push(40, 8, 8, 0, 0, 12);
    pulse_start(40, 0); set_mode(mw(1, 1, 0)); set_mode(10'h183);
    pulse_start(3, 0); drain("R12");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule